// File: doc/BRIEF.md
# Digest Engine Register Front-End

This block is the software-facing register shell of a message digest accelerator. It has a 32-bit register bus with separate read and write strobes. Through this bus software can hold the engine in a soft reset, program the message length in bits as a 64-bit value, and choose the algorithm and the input byte order. It can also enable and acknowledge interrupt causes and drain the finished digest one word at a time from a single queue address. The hash rounds are not part of this block. On the engine side it has a stub port. Message words go out on that port after byte reordering. A done strobe comes back on it with the full digest vector.

Message data reaches the block on its own write strobe. A word is forwarded only once the control register has been written after the last soft reset. Any earlier word is dropped and raises an error cause. When the engine signals done, the digest is loaded into a read-once queue. The queue holds as many words as the selected algorithm produces. A read that finds the queue empty returns zero and raises a second error cause.

Top module: `hash_regfront`

## Requirements
- R1: Word offsets on the register bus are 0x00 reset, 0x04 length upper word, 0x08 length lower word, 0x0C control, 0x10 interrupt status, 0x14 interrupt enable, 0x18 interrupt clear, and 0x1C result queue. Read data appears on `busRdData` in the cycle after `busRdEn`. An address at or above 0x20, or one that is not word-aligned, reads zero and is not written. Reading the clear offset returns zero.
- R2: Writing 1 to bit 0 of the reset register drives `coreRst` high. From the same edge, the length words, the control register, the status bits and the queue are cleared and held at zero until 0 is written. The interrupt enable keeps its value. The reset register reads back its bit.
- R3: Control bits [1:0] select the algorithm and appear on `coreAlgo`: 0 is MD5, 1 is SHA-1, 2 is SHA-224 and 3 is SHA-256. Bits [9:8] select the byte order. All other control bits read zero.
- R4: `coreLenBits` is {upper word, lower word}, the message size in bits.
- R5: A message word written while configured appears on `coreData` one cycle later, qualified by `coreDataValid`. Input bytes are named b3..b0 with b0 in bits [7:0], and the output is listed from its top byte down. Order 0 gives b3 b2 b1 b0. Order 1 gives b0 b1 b2 b3. Order 2 gives b2 b3 b1 b0. Order 3 gives b1 b0 b3 b2.
- R6: A message word written before the control register has been written since the last soft reset is dropped and sets status bit 3.
- R7: A done strobe loads the queue with 4, 5, 7 or 8 words for algorithms 0 to 3. Word 0 is in digest bits [31:0] and is read first. The strobe sets status bits 0 (results available) and 1 (new result).
- R8: Each read of the queue offset pops one word. A read while the queue is empty returns zero and sets status bit 2.
- R9: Writing to the clear offset clears each status bit written as 1. A cause that is set in the same cycle stays set.
- R10: `irq` is high exactly when some status bit and its enable bit are both 1. The 4-bit enable resets to zero.
- R11: A done strobe that arrives while the soft reset is held has no effect on the queue or the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 6 | Byte address of the register access |
| busWrEn | input | 1 | Register write strobe |
| busWrData | input | 32 | Register write data |
| busRdEn | input | 1 | Register read strobe |
| busRdData | output | 32 | Read data, valid the cycle after the strobe |
| msgWrEn | input | 1 | Message data write strobe |
| msgWrData | input | 32 | Message data word |
| coreRst | output | 1 | Soft reset to the engine |
| coreAlgo | output | 2 | Selected algorithm |
| coreLenBits | output | 64 | Message length in bits |
| coreDataValid | output | 1 | Reordered message word valid |
| coreData | output | 32 | Reordered message word |
| coreDone | input | 1 | Engine finished strobe |
| coreDigest | input | 256 | Digest words, word k at bits [32k+31:32k] |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a collision inside one cycle. One is a done strobe in the same cycle as an interrupt-clear write that names the bits the strobe sets. Another is an empty-queue pop close to a reload. The stimulus lines these up on a single falling edge and then reads status back. A behavioural model checks every cycle: a word queue for the digest and plain variables for the registers. It also follows the byte-order and word-count choices through each algorithm, so a wrong count shows up as an early or missing empty-read cause.

// File: rtl/hash_regfront_pkg.sv
package hash_regfront_pkg;

  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 6;
  localparam int Q_DEPTH  = 8;

  typedef enum logic [1:0] {
    ALG_MD5    = 2'd0,
    ALG_SHA1   = 2'd1,
    ALG_SHA224 = 2'd2,
    ALG_SHA256 = 2'd3
  } algo_e;

  // Register word indices (byte offset / 4)
  localparam logic [2:0] IDX_RESET  = 3'd0;
  localparam logic [2:0] IDX_LENHI  = 3'd1;
  localparam logic [2:0] IDX_LENLO  = 3'd2;
  localparam logic [2:0] IDX_CTRL   = 3'd3;
  localparam logic [2:0] IDX_STATUS = 3'd4;
  localparam logic [2:0] IDX_INTEN  = 3'd5;
  localparam logic [2:0] IDX_CLEAR  = 3'd6;
  localparam logic [2:0] IDX_QUEUE  = 3'd7;

  // Status bit positions
  localparam int ST_AVAIL = 0;
  localparam int ST_NEW   = 1;
  localparam int ST_EMPTY = 2;
  localparam int ST_EARLY = 3;

  typedef struct packed {
    logic       wrReset;
    logic       wrLenHi;
    logic       wrLenLo;
    logic       wrCtrl;
    logic       wrIntEn;
    logic       wrIntClr;
    logic       popQueue;
    logic       rdEn;
    logic       rdHit;
    logic [2:0] rdSel;
  } strobe_t;

  function automatic logic [3:0] digestWords(input logic [1:0] algo);
    case (algo_e'(algo))
      ALG_MD5:    digestWords = 4'd4;
      ALG_SHA1:   digestWords = 4'd5;
      ALG_SHA224: digestWords = 4'd7;
      default:    digestWords = 4'd8;
    endcase
  endfunction

  function automatic logic [31:0] reorderBytes(input logic [31:0] w,
                                               input logic [1:0] order);
    case (order)
      2'd0:    reorderBytes = w;
      2'd1:    reorderBytes = {w[7:0],   w[15:8],  w[23:16], w[31:24]};
      2'd2:    reorderBytes = {w[23:16], w[31:24], w[15:8],  w[7:0]};
      default: reorderBytes = {w[15:8],  w[7:0],   w[31:24], w[23:16]};
    endcase
  endfunction

endpackage

// File: rtl/hash_regfront_ctrl.sv
module hash_regfront_ctrl
  import hash_regfront_pkg::*;
#(
  parameter int ADDR_BITS = ADDR_W
) (
  input  logic [ADDR_BITS-1:0] busAddr,
  input  logic                 busWrEn,
  input  logic                 busRdEn,
  output strobe_t              strb
);

  logic       inWindow;
  logic [2:0] wordIdx;
  logic       wrOk;

  assign inWindow = (busAddr[1:0] == 2'b00) && (busAddr[ADDR_BITS-1:5] == '0);
  assign wordIdx  = busAddr[4:2];
  assign wrOk     = busWrEn && inWindow;

  always_comb begin
    strb          = '0;
    strb.wrReset  = wrOk && (wordIdx == IDX_RESET);
    strb.wrLenHi  = wrOk && (wordIdx == IDX_LENHI);
    strb.wrLenLo  = wrOk && (wordIdx == IDX_LENLO);
    strb.wrCtrl   = wrOk && (wordIdx == IDX_CTRL);
    strb.wrIntEn  = wrOk && (wordIdx == IDX_INTEN);
    strb.wrIntClr = wrOk && (wordIdx == IDX_CLEAR);
    strb.popQueue = busRdEn && inWindow && (wordIdx == IDX_QUEUE);
    strb.rdEn     = busRdEn;
    strb.rdHit    = busRdEn && inWindow;
    strb.rdSel    = wordIdx;
  end

endmodule

// File: rtl/hash_regfront_dp.sv
module hash_regfront_dp
  import hash_regfront_pkg::*;
#(
  parameter int DEPTH = Q_DEPTH,
  parameter int DW    = DATA_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [DW-1:0]      busWrData,
  input  logic               msgWrEn,
  input  logic [DW-1:0]      msgWrData,
  input  logic               coreDone,
  input  logic [DEPTH*DW-1:0] coreDigest,
  output logic [DW-1:0]      busRdData,
  output logic               coreRst,
  output logic [1:0]         coreAlgo,
  output logic [2*DW-1:0]    coreLenBits,
  output logic               coreDataValid,
  output logic [DW-1:0]      coreData,
  output logic               irq,
  output logic [3:0]         statusVec,
  output logic [3:0]         intEnVec,
  output logic [$clog2(DEPTH+1)-1:0] qCount
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = $clog2(DEPTH);

  logic              softRst;
  logic              hold;
  logic [DW-1:0]     lenHi, lenLo;
  logic [1:0]        algo, order;
  logic              cfgDone;
  logic [3:0]        status, intEn;
  logic [DW-1:0]     qWords [DEPTH];
  logic [PTR_W-1:0]  rdPtr;
  logic              qEmpty;
  logic              popEmpty;
  logic              earlyWr;
  logic [3:0]        setMask, clrMask;
  logic [DW-1:0]     qHead;

  assign hold     = strb.wrReset ? busWrData[0] : softRst;
  assign qEmpty   = (qCount == '0);
  assign popEmpty = strb.popQueue && qEmpty;
  assign earlyWr  = msgWrEn && !cfgDone;
  assign qHead    = qEmpty ? '0 : qWords[rdPtr];

  always_comb begin
    setMask           = '0;
    setMask[ST_AVAIL] = coreDone;
    setMask[ST_NEW]   = coreDone;
    setMask[ST_EMPTY] = popEmpty;
    setMask[ST_EARLY] = earlyWr;
    clrMask           = strb.wrIntClr ? busWrData[3:0] : 4'b0;
  end

  // Soft reset and interrupt enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      softRst <= 1'b0;
      intEn   <= '0;
    end else begin
      softRst <= hold;
      if (strb.wrIntEn) intEn <= busWrData[3:0];
    end
  end

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenHi   <= '0;
      lenLo   <= '0;
      algo    <= '0;
      order   <= '0;
      cfgDone <= 1'b0;
    end else if (hold) begin
      lenHi   <= '0;
      lenLo   <= '0;
      algo    <= '0;
      order   <= '0;
      cfgDone <= 1'b0;
    end else begin
      if (strb.wrLenHi) lenHi <= busWrData;
      if (strb.wrLenLo) lenLo <= busWrData;
      if (strb.wrCtrl) begin
        algo    <= busWrData[1:0];
        order   <= busWrData[9:8];
        cfgDone <= 1'b1;
      end
    end
  end

  // Interrupt status, write-one-to-clear with set priority
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     status <= '0;
    else if (hold) status <= '0;
    else           status <= (status & ~clrMask) | setMask;
  end

  // Result queue
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qCount <= '0;
      rdPtr  <= '0;
      for (int i = 0; i < DEPTH; i++) qWords[i] <= '0;
    end else if (hold) begin
      qCount <= '0;
      rdPtr  <= '0;
    end else if (coreDone) begin
      qCount <= CNT_W'(digestWords(algo));
      rdPtr  <= '0;
      for (int i = 0; i < DEPTH; i++) qWords[i] <= coreDigest[i*DW +: DW];
    end else if (strb.popQueue && !qEmpty) begin
      qCount <= qCount - 1'b1;
      rdPtr  <= rdPtr + 1'b1;
    end
  end

  // Registered read data
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdData <= '0;
    end else if (strb.rdEn) begin
      if (!strb.rdHit) begin
        busRdData <= '0;
      end else begin
        case (strb.rdSel)
          IDX_RESET:  busRdData <= {{(DW-1){1'b0}}, softRst};
          IDX_LENHI:  busRdData <= lenHi;
          IDX_LENLO:  busRdData <= lenLo;
          IDX_CTRL:   busRdData <= {{(DW-10){1'b0}}, order, 6'b0, algo};
          IDX_STATUS: busRdData <= {{(DW-4){1'b0}}, status};
          IDX_INTEN:  busRdData <= {{(DW-4){1'b0}}, intEn};
          IDX_QUEUE:  busRdData <= qHead;
          default:    busRdData <= '0;
        endcase
      end
    end
  end

  // Message data forwarding with byte reorder
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coreDataValid <= 1'b0;
      coreData      <= '0;
    end else begin
      coreDataValid <= msgWrEn && !hold && cfgDone;
      if (msgWrEn && !hold && cfgDone) coreData <= reorderBytes(msgWrData, order);
    end
  end

  assign coreRst     = softRst;
  assign coreAlgo    = algo;
  assign coreLenBits = {lenHi, lenLo};
  assign irq         = |(status & intEn);
  assign statusVec   = status;
  assign intEnVec    = intEn;

endmodule

// File: rtl/hash_regfront.sv
module hash_regfront
  import hash_regfront_pkg::*;
#(
  parameter int ADDR_BITS = ADDR_W,
  parameter int DEPTH     = Q_DEPTH
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_BITS-1:0]  busAddr,
  input  logic                  busWrEn,
  input  logic [31:0]           busWrData,
  input  logic                  busRdEn,
  output logic [31:0]           busRdData,
  input  logic                  msgWrEn,
  input  logic [31:0]           msgWrData,
  output logic                  coreRst,
  output logic [1:0]            coreAlgo,
  output logic [63:0]           coreLenBits,
  output logic                  coreDataValid,
  output logic [31:0]           coreData,
  input  logic                  coreDone,
  input  logic [DEPTH*32-1:0]   coreDigest,
  output logic                  irq
);

  strobe_t                       strb;
  logic [3:0]                    statusVec;
  logic [3:0]                    intEnVec;
  logic [$clog2(DEPTH+1)-1:0]    qCount;

  hash_regfront_ctrl #(.ADDR_BITS(ADDR_BITS)) i_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strb    (strb)
  );

  hash_regfront_dp #(.DEPTH(DEPTH), .DW(32)) i_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .busWrData     (busWrData),
    .msgWrEn       (msgWrEn),
    .msgWrData     (msgWrData),
    .coreDone      (coreDone),
    .coreDigest    (coreDigest),
    .busRdData     (busRdData),
    .coreRst       (coreRst),
    .coreAlgo      (coreAlgo),
    .coreLenBits   (coreLenBits),
    .coreDataValid (coreDataValid),
    .coreData      (coreData),
    .irq           (irq),
    .statusVec     (statusVec),
    .intEnVec      (intEnVec),
    .qCount        (qCount)
  );

endmodule

// File: rtl/hash_regfront_chk.sv
module hash_regfront_chk
  import hash_regfront_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             coreRst,
  input logic [1:0]       coreAlgo,
  input logic [63:0]      coreLenBits,
  input logic             coreDataValid,
  input logic [31:0]      busWrData,
  input logic             coreDone,
  input logic             irq,
  input strobe_t          strb,
  input logic [3:0]       statusVec,
  input logic [3:0]       intEnVec,
  input logic [CNT_W-1:0] qCount
);

  assert_rst_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    coreRst |-> (coreLenBits == 64'd0) && (coreAlgo == 2'd0) && (statusVec == 4'd0));

  assert_rst_blocks_data_R2: assert property (@(posedge clk) disable iff (!rstN)
    coreRst |=> !coreDataValid);

  assert_len_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrLenLo && !coreRst) |=> (coreLenBits[31:0] == $past(busWrData)));

  assert_done_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    (coreDone && !coreRst && !strb.wrReset) |=>
      ((qCount == CNT_W'(digestWords($past(coreAlgo)))) && (statusVec[1:0] == 2'b11)));

  assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.popQueue && (qCount == '0) && !coreRst && !strb.wrReset) |=> statusVec[ST_EMPTY]);

  assert_w1c_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrIntClr && busWrData[ST_NEW] && !coreDone) |=> !statusVec[ST_NEW]);

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rstN)
    (intEnVec == 4'd0) |-> !irq);

endmodule

bind hash_regfront hash_regfront_chk #(.CNT_W($clog2(DEPTH+1))) i_chk (
  .clk           (clk),
  .rstN          (rstN),
  .coreRst       (coreRst),
  .coreAlgo      (coreAlgo),
  .coreLenBits   (coreLenBits),
  .coreDataValid (coreDataValid),
  .busWrData     (busWrData),
  .coreDone      (coreDone),
  .irq           (irq),
  .strb          (strb),
  .statusVec     (statusVec),
  .intEnVec      (intEnVec),
  .qCount        (qCount)
);

// File: tb/test_hash_regfront.sv
`timescale 1ns/1ps
module test_hash_regfront;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [5:0]   busAddr = '0;
  logic         busWrEn = 1'b0;
  logic [31:0]  busWrData = '0;
  logic         busRdEn = 1'b0;
  logic [31:0]  busRdData;
  logic         msgWrEn = 1'b0;
  logic [31:0]  msgWrData = '0;
  logic         coreRst;
  logic [1:0]   coreAlgo;
  logic [63:0]  coreLenBits;
  logic         coreDataValid;
  logic [31:0]  coreData;
  logic         coreDone = 1'b0;
  logic [255:0] coreDigest = '0;
  logic         irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hash_regfront i_hash_regfront (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .msgWrEn(msgWrEn), .msgWrData(msgWrData), .coreRst(coreRst),
    .coreAlgo(coreAlgo), .coreLenBits(coreLenBits),
    .coreDataValid(coreDataValid), .coreData(coreData),
    .coreDone(coreDone), .coreDigest(coreDigest), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic int wordsOf(input logic [1:0] a);
    if (a == 2'd0) return 4;
    if (a == 2'd1) return 5;
    if (a == 2'd2) return 7;
    return 8;
  endfunction

  function automatic logic [31:0] swapModel(input logic [31:0] w, input logic [1:0] o);
    logic [7:0] b [4];
    for (int i = 0; i < 4; i++) b[i] = w[i*8 +: 8];
    case (o)
      2'd0: return {b[3], b[2], b[1], b[0]};
      2'd1: return {b[0], b[1], b[2], b[3]};
      2'd2: return {b[2], b[3], b[1], b[0]};
      default: return {b[1], b[0], b[3], b[2]};
    endcase
  endfunction

  function automatic logic [31:0] digestWord(input int seed, input int k);
    return 32'hC0DE_0000 ^ (seed << 12) ^ (k * 32'h0101);
  endfunction

  logic        mRst, mCfg, mDv;
  logic [31:0] mHi, mLo, mRd, mDd;
  logic [1:0]  mAlgo, mOrd;
  logic [3:0]  mStat, mEn;
  logic [31:0] mq[$];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mRst = 0; mCfg = 0; mDv = 0; mHi = 0; mLo = 0; mRd = 0; mDd = 0;
      mAlgo = 0; mOrd = 0; mStat = 0; mEn = 0; mq.delete();
    end else begin
      logic aligned, newRst, popE, popOk;
      logic [3:0] setm, clr;
      aligned = (busAddr[1:0] == 2'b00) && (busAddr < 6'h20);
      if (busRdEn) begin
        if (!aligned) mRd = 0;
        else case (busAddr)
          6'h00: mRd = {31'b0, mRst};
          6'h04: mRd = mHi;
          6'h08: mRd = mLo;
          6'h0C: mRd = {22'b0, mOrd, 6'b0, mAlgo};
          6'h10: mRd = {28'b0, mStat};
          6'h14: mRd = {28'b0, mEn};
          6'h1C: mRd = (mq.size() > 0) ? mq[0] : 32'h0;
          default: mRd = 0;
        endcase
      end
      newRst = (busWrEn && busAddr == 6'h00) ? busWrData[0] : mRst;
      popE  = busRdEn && busAddr == 6'h1C && mq.size() == 0;
      popOk = busRdEn && busAddr == 6'h1C && mq.size() > 0;
      mDv = msgWrEn && !newRst && mCfg;
      if (mDv) mDd = swapModel(msgWrData, mOrd);
      if (busWrEn && busAddr == 6'h14) mEn = busWrData[3:0];
      if (newRst) begin
        mHi = 0; mLo = 0; mAlgo = 0; mOrd = 0; mCfg = 0; mStat = 0; mq.delete();
      end else begin
        setm = {msgWrEn && !mCfg, popE, coreDone, coreDone};
        clr  = (busWrEn && busAddr == 6'h18) ? busWrData[3:0] : 4'h0;
        mStat = (mStat & ~clr) | setm;
        if (coreDone) begin
          mq.delete();
          for (int k = 0; k < wordsOf(mAlgo); k++) mq.push_back(coreDigest[k*32 +: 32]);
        end else if (popOk) begin
          void'(mq.pop_front());
        end
        if (busWrEn && busAddr == 6'h04) mHi = busWrData;
        if (busWrEn && busAddr == 6'h08) mLo = busWrData;
        if (busWrEn && busAddr == 6'h0C) begin
          mAlgo = busWrData[1:0]; mOrd = busWrData[9:8]; mCfg = 1;
        end
      end
      mRst = newRst;
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(busRdData == mRd, "R1 read data", busRdData, mRd);
      chk(coreDataValid == mDv, "R5 data valid", coreDataValid, mDv);
      if (mDv) chk(coreData == mDd, "R5 data word", coreData, mDd);
      chk(coreAlgo == mAlgo, "R3 algorithm", coreAlgo, mAlgo);
      chk(coreLenBits == {mHi, mLo}, "R4 length", coreLenBits, {mHi, mLo});
      chk(coreRst == mRst, "R2 soft reset", coreRst, mRst);
      chk(irq == |(mStat & mEn), "R10 irq", irq, |(mStat & mEn));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); busWrEn = 1; busAddr = a; busWrData = d;
    @(negedge clk); busWrEn = 0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); busRdEn = 1; busAddr = a;
    @(negedge clk); busRdEn = 0;
    chk(busRdData == exp, tag, busRdData, exp);
  endtask

  task automatic msg(input logic [31:0] d);
    @(negedge clk); msgWrEn = 1; msgWrData = d;
    @(negedge clk); msgWrEn = 0;
  endtask

  task automatic loadDigest(input int seed);
    for (int k = 0; k < 8; k++) coreDigest[k*32 +: 32] = digestWord(seed, k);
  endtask

  task automatic pulseDone(input int seed);
    @(negedge clk); loadDigest(seed); coreDone = 1;
    @(negedge clk); coreDone = 0;
  endtask

  logic [31:0] orderExp [4];

  initial begin
    orderExp[0] = 32'h11223344; orderExp[1] = 32'h44332211;
    orderExp[2] = 32'h22113344; orderExp[3] = 32'h33441122;
    repeat (3) @(negedge clk);
    rstN = 1;
    // reset state
    rd(6'h10, 32'h0, "R9 status after reset");
    rd(6'h14, 32'h0, "R10 enable resets to zero");
    chk(irq == 1'b0, "R10 irq low after reset", irq, 0);

    wr(6'h14, 32'hF);
    wr(6'h00, 1); wr(6'h00, 0);
    // early data write
    msg(32'hDEADBEEF);
    chk(coreDataValid == 1'b0, "R6 early word dropped", coreDataValid, 0);
    rd(6'h10, 32'h8, "R6 early write cause");
    chk(irq == 1'b1, "R10 irq on cause", irq, 1);
    wr(6'h18, 32'h8);
    rd(6'h10, 32'h0, "R9 clear early cause");

    // length and control
    wr(6'h04, 32'h0000_0001);
    wr(6'h08, 32'h0000_0200);
    chk(coreLenBits == 64'h1_0000_0200, "R4 length bits", coreLenBits, 64'h1_0000_0200);
    rd(6'h04, 32'h1, "R1 length upper readback");
    wr(6'h0C, 32'hFFFF_F2FE);
    rd(6'h0C, 32'h0000_0202, "R3 control readback");

    // byte orders
    for (int o = 0; o < 4; o++) begin
      wr(6'h0C, o << 8);
      msg(32'h11223344);
      chk(coreDataValid && coreData == orderExp[o], "R5 byte order",
          coreData, orderExp[o]);
    end

    // digests for each algorithm
    for (int a = 0; a < 4; a++) begin
      wr(6'h0C, a);
      pulseDone(a + 1);
      rd(6'h10, 32'h3, "R7 done causes");
      for (int k = 0; k < wordsOf(a); k++)
        rd(6'h1C, digestWord(a + 1, k), "R7 digest word");
      rd(6'h1C, 32'h0, "R8 empty read returns zero");
      rd(6'h10, 32'h7, "R8 empty read cause");
      wr(6'h18, 32'h7);
      rd(6'h10, 32'h0, "R9 clear all");
    end

    // clear and set in the same cycle
    @(negedge clk); loadDigest(9); coreDone = 1;
    busWrEn = 1; busAddr = 6'h18; busWrData = 32'h3;
    @(negedge clk); coreDone = 0; busWrEn = 0;
    rd(6'h10, 32'h3, "R9 set wins over clear");

    // unmapped
    rd(6'h20, 32'h0, "R1 unmapped read");
    rd(6'h18, 32'h0, "R1 clear reads zero");

    // soft reset
    wr(6'h04, 32'h5); wr(6'h08, 32'h6); wr(6'h0C, 32'h103);
    wr(6'h00, 1);
    rd(6'h00, 32'h1, "R2 reset readback");
    rd(6'h04, 32'h0, "R2 length cleared");
    rd(6'h0C, 32'h0, "R2 control cleared");
    rd(6'h10, 32'h0, "R2 status cleared");
    rd(6'h14, 32'hF, "R2 enable kept");
    pulseDone(12);
    rd(6'h10, 32'h0, "R11 done ignored in reset");
    wr(6'h00, 0);
    rd(6'h1C, 32'h0, "R11 queue stays empty");
    rd(6'h10, 32'h4, "R11 only empty cause");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule